// File: doc/BRIEF.md
# Iterative Division Step Unit

This block divides by a sequence of conditional subtract-and-shift steps on a 36-bit accumulator. A 16-bit divisor is sign-extended to the accumulator width and scaled up by 2^15. Each step subtracts the scaled divisor from the accumulator as a trial. A negative trial is thrown away and the accumulator is only doubled. A non-negative trial is kept, doubled, and a one is placed in the least significant bit.

A start pulse loads the dividend and the divisor. The internal sequencer then performs one step per clock for count+1 steps, so a count field of 0 to 255 selects 1 to 256 steps. After the last step it raises a one-cycle done pulse. For an unsigned 16-bit quotient the caller programs a count of 15, which gives 16 steps. The quotient is then in the low 16 bits and the partial remainder is in the upper bits. Any correction for signed operands is left to the caller.

Top module: `div_step_unit`

## Requirements
- R1: After reset the accumulator output is 0, busy_o and done_o are low, and zero_o is high.
- R2: A start_i high while busy_o is low loads dividend_i into the accumulator at that clock edge. busy_o is high in the following cycle.
- R3: Each step forms trial = acc - (sext36(divisor) << 15) modulo 2^36. If trial bit 35 is 1, the new acc is (acc << 1). Otherwise the new acc is (trial << 1) | 1. All results are truncated to 36 bits.
- R4: The divisor is sign-extended from bit 15. A divisor of 0xFFFF acts as -1, so from acc 0 a single step yields 0x000010001.
- R5: A count_i of n performs exactly n+1 steps, one per clock, for any n from 0 to 255.
- R6: done_o is high for exactly one cycle, in the cycle right after the clock edge that performs the last step. busy_o is low in that same cycle.
- R7: A start_i while busy_o is high has no effect on the result, the step count or the timing of done_o.
- R8: While idle and with no start, the accumulator output holds its value.
- R9: zero_o is high exactly when acc_o is zero. minus_o equals acc_o bit 35.
- R10: With a divisor from 1 to 0x7FFF, a dividend below both divisor*2^16 and 2^31, and count 15, acc_o[15:0] equals the unsigned integer quotient dividend/divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division run when idle |
| dividend_i | input | 36 | Initial accumulator value |
| divisor_i | input | 16 | Divisor, sign-extended internally |
| count_i | input | 8 | Step count minus one |
| acc_o | output | 36 | Accumulator; quotient bits in the low part |
| busy_o | output | 1 | Steps in progress |
| done_o | output | 1 | One-cycle pulse after the final step |
| zero_o | output | 1 | Accumulator equals zero |
| minus_o | output | 1 | Accumulator bit 35 |

## Verification
If a single step chooses the wrong branch, the error shows at once in the least significant bit of acc_o and in every higher bit after it, and it is still visible when done_o rises. A fault in the step counter moves the done_o pulse away from cycle count+1 after the load edge, so the bench measures that latency cycle by cycle. A sequencer that restarts on a start pulse while busy would change both the final accumulator and the done timing before the run could finish. A fault in the flag logic shows up in the same cycle as the accumulator value it describes.

// File: rtl/div_step_pkg.sv
package div_step_pkg;
  localparam int unsigned ACC_W = 36;
  localparam int unsigned DIV_W = 16;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned ALIGN = 15;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;
endpackage

// File: rtl/div_step_core.sv
module div_step_core #(
  parameter int unsigned ACC_W = div_step_pkg::ACC_W,
  parameter int unsigned DIV_W = div_step_pkg::DIV_W,
  parameter int unsigned ALIGN = div_step_pkg::ALIGN
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             qbit_o
);
  localparam int unsigned EXT_W = ACC_W - DIV_W;

  logic [ACC_W-1:0] div_ext;
  logic [ACC_W-1:0] scaled;
  logic [ACC_W-1:0] trial;

  always_comb begin
    div_ext = {{EXT_W{divisor_i[DIV_W-1]}}, divisor_i};
    scaled  = div_ext << ALIGN;
    trial   = acc_i - scaled;
    qbit_o  = ~trial[ACC_W-1];
    if (qbit_o) acc_o = {trial[ACC_W-2:0], 1'b1};
    else        acc_o = {acc_i[ACC_W-2:0], 1'b0};
  end
endmodule

// File: rtl/div_step_seq.sv
module div_step_seq
  import div_step_pkg::*;
#(
  parameter int unsigned CNT_W = div_step_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             load_o,
  output logic             step_o,
  output logic             busy_o,
  output logic             done_o
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] left_q;
  logic             last_w;

  assign busy_o = (state_q == ST_RUN);
  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = busy_o;
  assign last_w = busy_o && (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          left_q  <= count_i;
        end
        ST_RUN: begin
          if (last_w) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
          end else begin
            left_q <= left_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R6: done never repeats in the next cycle
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6: done only after a running cycle
  a_r6_done_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));
  // R5, R7: counter moves down by one per step regardless of start
  a_r5_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && left_q != '0) |=> (busy_o && left_q == $past(left_q) - 1'b1));
endmodule

// File: rtl/div_step_unit.sv
module div_step_unit
  import div_step_pkg::*;
#(
  parameter int unsigned ACC_W = div_step_pkg::ACC_W,
  parameter int unsigned DIV_W = div_step_pkg::DIV_W,
  parameter int unsigned CNT_W = div_step_pkg::CNT_W,
  parameter int unsigned ALIGN = div_step_pkg::ALIGN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ACC_W-1:0] dividend_i,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             zero_o,
  output logic             minus_o
);
  logic [ACC_W-1:0] acc_q;
  logic [DIV_W-1:0] div_q;
  logic [ACC_W-1:0] acc_next;
  logic             qbit;
  logic             load;
  logic             step;

  div_step_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .count_i (count_i),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  div_step_core #(.ACC_W(ACC_W), .DIV_W(DIV_W), .ALIGN(ALIGN)) u_core (
    .acc_i     (acc_q),
    .divisor_i (div_q),
    .acc_o     (acc_next),
    .qbit_o    (qbit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      div_q <= '0;
    end else if (load) begin
      acc_q <= dividend_i;
      div_q <= divisor_i;
    end else if (step) begin
      acc_q <= acc_next;
    end
  end

  assign acc_o   = acc_q;
  assign zero_o  = (acc_q == '0);
  assign minus_o = acc_q[ACC_W-1];

  // R2: idle start captures the dividend
  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && acc_o == $past(dividend_i)));
  // R8: idle accumulator is frozen
  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(acc_o));
  // R3: the inserted bit is the quotient decision of the step
  a_r3_qbit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (acc_o[0] == $past(qbit)));
endmodule

// File: tb/div_step_unit_tb_top.sv
`timescale 1ns/1ps
module div_step_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [35:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic [7:0]  count = '0;
  logic [35:0] acc;
  logic        busy, done, zero, minus;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  div_step_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dividend_i(dividend),
    .divisor_i(divisor), .count_i(count), .acc_o(acc), .busy_o(busy),
    .done_o(done), .zero_o(zero), .minus_o(minus)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] ref_step(input logic [35:0] a, input logic [15:0] d);
    logic [35:0] s, t;
    s = {{20{d[15]}}, d} << 15;
    t = a - s;
    return t[35] ? {a[34:0], 1'b0} : {t[34:0], 1'b1};
  endfunction

  task automatic run(input logic [35:0] nd, input logic [15:0] dv, input logic [7:0] n,
                     input bit poke, output logic [35:0] res);
    logic [35:0] exp;
    bit got;
    int at;
    exp = nd;
    for (int i = 0; i <= int'(n); i++) exp = ref_step(exp, dv);
    @(negedge clk);
    dividend = nd; divisor = dv; count = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after load", 64'(busy), 64'd1);
    got = 0; at = 0;
    for (int k = 1; k <= 300 && !got; k++) begin
      if (poke && k == 1) begin
        start = 1'b1; dividend = ~nd; count = 8'd0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (done) begin got = 1; at = k; end
    end
    start = 1'b0;
    chk(at == int'(n) + 1, poke ? "R7 done timing with start while busy" : "R5 step count",
        64'(at), 64'(int'(n) + 1));
    chk(acc == exp, poke ? "R7 result with start while busy" : "R3 accumulator", 64'(acc), 64'(exp));
    chk(busy == 1'b0, "R6 busy low with done", 64'(busy), 64'd0);
    chk(zero == (acc == 36'd0) && minus == acc[35], "R9 flags",
        {62'd0, zero, minus}, {62'd0, acc == 36'd0, acc[35]});
    res = acc;
    @(negedge clk);
    chk(done == 1'b0, "R6 done single cycle", 64'(done), 64'd0);
    chk(acc == res, "R8 idle hold", 64'(acc), 64'(res));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [35:0] r;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(acc == 36'd0 && !busy && !done && zero, "R1 reset state",
        {acc, 24'd0, busy, done, zero}, {36'd0, 24'd0, 3'b001});
    rst_n = 1'b1;
    @(negedge clk);
    // R4 negative divisor, single step from zero
    run(36'd0, 16'hFFFF, 8'd0, 1'b0, r);
    chk(r == 36'h0_0001_0001, "R4 sign extension", 64'(r), 64'h1_0001);
    // R10 directed quotient
    run(36'd100, 16'd7, 8'd15, 1'b0, r);
    chk(r[15:0] == 16'd14, "R10 quotient 100/7", 64'(r[15:0]), 64'd14);
    // R5 longest run
    run(36'h0_1234_5678, 16'h0ABC, 8'd255, 1'b0, r);
    // R7 start while busy, shortest and longer
    run(36'h0_0003_0000, 16'd5, 8'd0, 1'b1, r);
    run(36'h0_00FF_0000, 16'h0101, 8'd15, 1'b1, r);
    // R9 zero result
    run(36'd0, 16'd3, 8'd3, 1'b0, r);
    chk(zero == 1'b1, "R9 zero flag", 64'(zero), 64'd1);
    // random quotients
    for (int t = 0; t < 30; t++) begin
      logic [15:0] d;
      logic [31:0] lim, nd;
      d = 16'($urandom_range(32'h7FFF, 1));
      lim = {d, 16'd0};
      if (lim > 32'h7FFF_FFFF) lim = 32'h7FFF_FFFF;
      nd = $urandom % lim;
      run({4'd0, nd}, d, 8'd15, t[2], r);
      chk(r[15:0] == 16'(nd / {16'd0, d}), "R10 random quotient", 64'(r[15:0]), 64'(nd / {16'd0, d}));
    end
    // random raw step sequences, any divisor and count
    for (int t = 0; t < 20; t++) begin
      run({4'($urandom), 32'($urandom)}, 16'($urandom), 8'($urandom_range(40, 0)), t[0], r);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule